// File: doc/BRIEF.md
# Extended Capability List Walker

This block manages the chain of extended capability headers kept in a 4 KB configuration space that is stored as 1024 dwords in a single-port RAM. Each header dword holds a 16-bit capability ID, a 4-bit version and a 12-bit byte offset of the next header. A next offset of zero ends the chain, and the chain always begins at byte 0x100.

Two commands are accepted through a start/done/busy handshake. A lookup follows the chain one RAM read at a time and reports the byte offset of the first header whose ID matches, together with the offset of the header visited just before it. An append adds a header at a caller-chosen offset. At the base offset it simply writes the header. Anywhere else it first walks to the tail, using a search that can never match, then rewrites only the next-offset field of the tail header, and finally writes the new header. Malformed pointers, runaway chains and unusable append arguments end the command with the error output raised.

Top module: `extcap_walker`

## Requirements
- R1: If the dword at byte 0x100 reads as all zero, a lookup finishes with found offset 0, previous offset 0 and no error.
- R2: Headers are packed as ID in bits [15:0], version in bits [19:16] and next byte offset in bits [31:20]. A next offset of 0 marks the last header.
- R3: A lookup reports the offset of the first header in chain order whose ID equals the requested ID. The previous offset is that of the header read just before it, or 0 when the match is at 0x100.
- R4: A lookup with no matching ID reports found offset 0 and, as the previous offset, the offset of the last header in the chain.
- R5: A next offset below 0x100, above 0xFF8, or not a multiple of 4 ends the command with the error output set and found offset 0.
- R6: An append at offset 0x100 performs exactly one RAM write: the header {next=0, version, ID} at dword 0x40. It performs no reads.
- R7: An append at any other offset rewrites the tail header with its next field set to the new offset and bits [19:0] unchanged. It then writes the new header with next=0 and reports found offset equal to the new offset and previous offset equal to the tail. On an empty chain it is refused with an error and writes nothing.
- R8: An append whose offset is below 0x100 or not a multiple of 4, whose size is below 8, or whose offset plus size exceeds 4096 is refused with the error output set. It makes no RAM access.
- R9: A command reads at most MAX_HOPS headers. A chain that needs one more read ends with an error, so a cyclic chain always terminates.
- R10: busy is high from the cycle after an accepted start until done. done is a one-cycle pulse. A start while busy is ignored. The results and the error output hold their values until the next accepted start.
- R11: After reset, busy, done, error and both offsets are 0 and the RAM is not accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a command (taken only while idle) |
| cmd_i | input | 1 | 0 = lookup, 1 = append |
| id_i | input | 16 | Capability ID to find or to append |
| ver_i | input | 4 | Version for an appended header |
| off_i | input | 12 | Byte offset of the appended header |
| size_i | input | 13 | Byte size of the appended capability |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last command ended in error |
| found_off_o | output | 12 | Matched offset (lookup) or appended offset |
| prev_off_o | output | 12 | Offset visited before the match, or the tail |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | 10 | RAM dword address |
| mem_wdata_o | output | 32 | RAM write data |
| mem_rdata_i | input | 32 | RAM read data, valid one cycle after the read |

## Verification
A wrong current or previous offset register shows at the ports within one hop, as a RAM read at the wrong dword address. It also shows on the same command's done pulse as a wrong found or previous offset. A corrupted tail patch leaves the chain broken, and this appears on the next lookup either as a missing ID or as a pointer error. A hop counter that is off by one is exposed only by chains of exactly MAX_HOPS and MAX_HOPS+1 headers, so the sweep builds both.

// File: rtl/extcap_pkg.sv
package extcap_pkg;

    localparam int NEXT_W      = 12;
    localparam int SPACE_BYTES = 1 << NEXT_W;
    localparam int DW_AW       = NEXT_W - 2;

    typedef struct packed {
        logic [NEXT_W-1:0] nxt;
        logic [3:0]        ver;
        logic [15:0]       id;
    } ext_hdr_t;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_EVAL  = 3'd2,
        S_PATCH = 3'd3,
        S_WRITE = 3'd4
    } walk_state_e;

    typedef struct packed {
        walk_state_e       st;
        logic              app;
        logic [15:0]       id;
        logic [3:0]        ver;
        logic [NEXT_W-1:0] new_off;
        logic [NEXT_W-1:0] cur;
        logic [NEXT_W-1:0] prev;
        logic [NEXT_W-1:0] found;
        logic [19:0]       tail_low;
        logic              err;
        logic              done;
    } walk_regs_t;

endpackage

// File: rtl/extcap_off_check.sv
module extcap_off_check
    import extcap_pkg::*;
#(
    parameter int LO = 256,
    parameter int HI = SPACE_BYTES - 8
) (
    input  logic [NEXT_W-1:0] off_i,
    output logic              ok_o
);
    always_comb begin
        ok_o = (32'(off_i) >= 32'(LO)) && (32'(off_i) <= 32'(HI)) && (off_i[1:0] == 2'b00);
    end
endmodule

// File: rtl/extcap_hop_limiter.sv
module extcap_hop_limiter #(
    parameter int MAX_HOPS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic at_limit_o
);
    localparam int CW = $clog2(MAX_HOPS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != CW'(MAX_HOPS))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign at_limit_o = (cnt_q == CW'(MAX_HOPS));
endmodule

// File: rtl/extcap_walker.sv
module extcap_walker
    import extcap_pkg::*;
#(
    parameter int BASE_OFF = 256,
    parameter int MAX_HOPS = 1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        cmd_i,
    input  logic [15:0] id_i,
    input  logic [3:0]  ver_i,
    input  logic [11:0] off_i,
    input  logic [12:0] size_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        err_o,
    output logic [11:0] found_off_o,
    output logic [11:0] prev_off_o,
    output logic        mem_en_o,
    output logic        mem_we_o,
    output logic [9:0]  mem_addr_o,
    output logic [31:0] mem_wdata_o,
    input  logic [31:0] mem_rdata_i
);
    localparam int LAST_HDR = SPACE_BYTES - 8;
    localparam int MIN_SIZE = 8;
    localparam logic [NEXT_W-1:0] BASE = NEXT_W'(BASE_OFF);

    walk_regs_t q, d;
    ext_hdr_t   hdr;
    logic       nxt_ok, app_off_ok, app_ok;
    logic       hop_clr, hop_inc, hop_full;

    assign hdr = ext_hdr_t'(mem_rdata_i);

    extcap_off_check #(.LO(BASE_OFF), .HI(LAST_HDR)) u_nxt_chk (
        .off_i (hdr.nxt),
        .ok_o  (nxt_ok)
    );

    extcap_off_check #(.LO(BASE_OFF), .HI(LAST_HDR)) u_app_chk (
        .off_i (off_i),
        .ok_o  (app_off_ok)
    );

    extcap_hop_limiter #(.MAX_HOPS(MAX_HOPS)) u_hops (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (hop_clr),
        .inc_i      (hop_inc),
        .at_limit_o (hop_full)
    );

    assign app_ok = app_off_ok
                 && (size_i >= 13'(MIN_SIZE))
                 && ((14'(off_i) + 14'(size_i)) <= 14'(SPACE_BYTES));

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        hop_clr     = 1'b0;
        hop_inc     = 1'b0;
        mem_en_o    = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;

        case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    hop_clr   = 1'b1;
                    d.app     = cmd_i;
                    d.id      = id_i;
                    d.ver     = ver_i;
                    d.new_off = off_i;
                    d.cur     = BASE;
                    d.prev    = '0;
                    d.found   = '0;
                    d.err     = 1'b0;
                    if (cmd_i && !app_ok) begin
                        d.err  = 1'b1;
                        d.done = 1'b1;
                    end else if (cmd_i && (off_i == BASE)) begin
                        d.st = S_WRITE;
                    end else begin
                        d.st = S_READ;
                    end
                end
            end

            S_READ: begin
                mem_en_o   = 1'b1;
                mem_addr_o = q.cur[NEXT_W-1:2];
                hop_inc    = 1'b1;
                d.st       = S_EVAL;
            end

            S_EVAL: begin
                if ((q.cur == BASE) && (mem_rdata_i == '0)) begin
                    d.err  = q.app;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else if (!q.app && (hdr.id == q.id)) begin
                    d.found = q.cur;
                    d.done  = 1'b1;
                    d.st    = S_IDLE;
                end else if (hdr.nxt == '0) begin
                    d.prev = q.cur;
                    if (q.app) begin
                        d.tail_low = mem_rdata_i[19:0];
                        d.st       = S_PATCH;
                    end else begin
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end else if (!nxt_ok || hop_full) begin
                    d.err  = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end else begin
                    d.prev = q.cur;
                    d.cur  = hdr.nxt;
                    d.st   = S_READ;
                end
            end

            S_PATCH: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.prev[NEXT_W-1:2];
                mem_wdata_o = {q.new_off, q.tail_low};
                d.st        = S_WRITE;
            end

            S_WRITE: begin
                mem_en_o    = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = q.new_off[NEXT_W-1:2];
                mem_wdata_o = {NEXT_W'(0), q.ver, q.id};
                d.found     = q.new_off;
                d.done      = 1'b1;
                d.st        = S_IDLE;
            end

            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o      = (q.st != S_IDLE);
    assign done_o      = q.done;
    assign err_o       = q.err;
    assign found_off_o = q.found;
    assign prev_off_o  = q.prev;
endmodule

// File: rtl/extcap_walker_chk.sv
module extcap_walker_chk #(
    parameter int BASE_OFF = 256
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        err_o,
    input logic [11:0] found_off_o,
    input logic [11:0] prev_off_o,
    input logic        mem_en_o,
    input logic        mem_we_o,
    input logic [9:0]  mem_addr_o
);
    localparam logic [9:0] BASE_DW = 10'(BASE_OFF / 4);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r10_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o || done_o));

    a_r10_results_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(found_off_o) && $stable(prev_off_o) && $stable(err_o)));

    a_r5_access_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en_o |-> (mem_addr_o >= BASE_DW));

    a_r8_no_access_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_en_o);

    a_r6_we_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_en_o);

    a_r9_err_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

bind extcap_walker extcap_walker_chk #(.BASE_OFF(BASE_OFF)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .found_off_o (found_off_o),
    .prev_off_o  (prev_off_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o)
);

// File: tb/extcap_walker_bench.sv
module extcap_walker_bench;
    localparam int HOPS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cmd_i = 1'b0;
    logic [15:0] id_i = '0;
    logic [3:0]  ver_i = '0;
    logic [11:0] off_i = '0;
    logic [12:0] size_i = '0;
    logic        busy_o, done_o, err_o;
    logic [11:0] found_off_o, prev_off_o;
    logic        mem_en_o, mem_we_o;
    logic [9:0]  mem_addr_o;
    logic [31:0] mem_wdata_o;
    logic [31:0] mem_rdata_i;

    logic [31:0] ram [1024];
    logic        bd_we = 1'b0;
    logic        bd_clr = 1'b0;
    logic [9:0]  bd_addr = '0;
    logic [31:0] bd_data = '0;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    logic [11:0] r_found, r_prev;
    logic        r_err;
    logic [11:0] offs [9];
    logic [15:0] ids  [9];
    logic [3:0]  vers [9];

    always #4 clk = ~clk;

    extcap_walker #(.BASE_OFF(256), .MAX_HOPS(HOPS)) u_extcap_walker (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
        .id_i(id_i), .ver_i(ver_i), .off_i(off_i), .size_i(size_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
        .found_off_o(found_off_o), .prev_off_o(prev_off_o),
        .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
    );

    always_ff @(posedge clk) begin
        if (bd_clr) begin
            for (int i = 0; i < 1024; i++) ram[i] <= '0;
        end else if (bd_we) begin
            ram[bd_addr] <= bd_data;
        end else if (mem_en_o) begin
            if (mem_we_o) ram[mem_addr_o] <= mem_wdata_o;
            mem_rdata_i <= ram[mem_addr_o];
        end
        if (mem_en_o && mem_we_o) wr_count <= wr_count + 1;
    end

    function automatic logic [31:0] mk(logic [11:0] n, logic [3:0] v, logic [15:0] i);
        return {n, v, i};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_ram();
        @(negedge clk) bd_clr = 1'b1;
        @(negedge clk) bd_clr = 1'b0;
    endtask

    task automatic poke(input logic [11:0] byte_off, input logic [31:0] v);
        @(negedge clk);
        bd_we = 1'b1; bd_addr = byte_off[11:2]; bd_data = v;
        @(negedge clk) bd_we = 1'b0;
    endtask

    task automatic run(input logic c, input logic [15:0] id, input logic [3:0] v,
                       input logic [11:0] off, input logic [12:0] sz);
        int n;
        @(negedge clk);
        cmd_i = c; id_i = id; ver_i = v; off_i = off; size_i = sz; start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done_o == 1'b1, "R10 done seen", 32'(done_o), 1);
        r_found = found_off_o; r_prev = prev_off_o; r_err = err_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done one cycle", 32'(done_o), 0);
    endtask

    task automatic find_chk(input logic [15:0] id, input logic [11:0] ef, input logic [11:0] ep,
                            input logic ee, input string req);
        run(1'b0, id, 4'h0, 12'h0, 13'h0);
        chk(r_err == ee, req, 32'(r_err), 32'(ee));
        chk(r_found == ef, req, 32'(r_found), 32'(ef));
        if (!ee) chk(r_prev == ep, req, 32'(r_prev), 32'(ep));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0;
        clear_ram();
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!busy_o && !done_o && !err_o, "R11 reset flags", {busy_o, done_o, err_o}, 0);
        chk(found_off_o == 0 && prev_off_o == 0, "R11 reset offsets", {found_off_o, prev_off_o}, 0);
        chk(!mem_en_o, "R11 no access", 32'(mem_en_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 empty chain
        find_chk(16'h0001, 12'h0, 12'h0, 1'b0, "R1 empty find");
        // R7 append on empty chain at non-base offset refused
        w0 = wr_count;
        run(1'b1, 16'h0005, 4'h1, 12'h200, 13'd16);
        chk(r_err == 1'b1, "R7 empty append err", 32'(r_err), 1);
        chk(wr_count == w0, "R7 empty append no write", wr_count, w0);

        // Sweep chains of 1..HOPS headers
        for (int n = 1; n <= HOPS; n++) begin
            clear_ram();
            for (int k = 0; k < n; k++) begin
                offs[k] = 12'(256 + k * (32 + 4 * n));
                ids[k]  = 16'(16 * n + k + 1);
                vers[k] = 4'(k + n);
                w0 = wr_count;
                run(1'b1, ids[k], vers[k], offs[k], 13'd32);
                chk(!r_err && r_found == offs[k], "R7 append result", {r_err, r_found}, {1'b0, offs[k]});
                if (k == 0) begin
                    chk(wr_count == w0 + 1, "R6 single write", wr_count, w0 + 1);
                end else begin
                    chk(r_prev == offs[k-1], "R7 append prev is tail", r_prev, offs[k-1]);
                    chk(wr_count == w0 + 2, "R7 two writes", wr_count, w0 + 2);
                end
            end
            for (int k = 0; k < n; k++) begin
                logic [31:0] e;
                e = mk((k == n - 1) ? 12'h0 : offs[k+1], vers[k], ids[k]);
                chk(ram[offs[k][11:2]] == e, "R2 R7 header layout", ram[offs[k][11:2]], e);
                find_chk(ids[k], offs[k], (k == 0) ? 12'h0 : offs[k-1], 1'b0, "R3 find match");
            end
            find_chk(16'hFFFF, 12'h0, offs[n-1], 1'b0, "R4 no match tail");
        end

        // R9: one header past the limit (chain of HOPS already present)
        offs[HOPS] = 12'h3C0;
        run(1'b1, 16'h0099, 4'h2, offs[HOPS], 13'd16);
        chk(!r_err && r_prev == offs[HOPS-1], "R9 append at limit ok", {r_err, r_prev}, {1'b0, offs[HOPS-1]});
        find_chk(16'hFFFF, 12'h0, 12'h0, 1'b1, "R9 chain over limit");
        find_chk(16'h0099, 12'h0, 12'h0, 1'b1, "R9 match beyond limit");
        clear_ram();
        poke(12'h100, mk(12'h100, 4'h0, 16'h0001));
        find_chk(16'hFFFF, 12'h0, 12'h0, 1'b1, "R9 self loop");

        // R3 duplicate IDs: first wins
        clear_ram();
        poke(12'h100, mk(12'h180, 4'h1, 16'h0007));
        poke(12'h180, mk(12'h1C0, 4'h1, 16'h0022));
        poke(12'h1C0, mk(12'h000, 4'h1, 16'h0022));
        find_chk(16'h0022, 12'h180, 12'h100, 1'b0, "R3 first duplicate");
        find_chk(16'h0007, 12'h100, 12'h000, 1'b0, "R3 base match prev 0");

        // R5 bad pointers and boundary
        poke(12'h100, mk(12'h0FC, 4'h0, 16'h0001));
        find_chk(16'hFFFF, 12'h0, 12'h0, 1'b1, "R5 below base");
        poke(12'h100, mk(12'h102, 4'h0, 16'h0001));
        find_chk(16'hFFFF, 12'h0, 12'h0, 1'b1, "R5 misaligned");
        poke(12'h100, mk(12'hFFC, 4'h0, 16'h0001));
        find_chk(16'hFFFF, 12'h0, 12'h0, 1'b1, "R5 above top");
        poke(12'h100, mk(12'hFF8, 4'h0, 16'h0001));
        poke(12'hFF8, mk(12'h000, 4'h0, 16'h0002));
        find_chk(16'hFFFF, 12'h0, 12'hFF8, 1'b0, "R5 top header legal");

        // R8 refused appends
        poke(12'hFF8, 32'h0);
        poke(12'h100, mk(12'h000, 4'h0, 16'h0001));
        w0 = wr_count;
        run(1'b1, 16'h0030, 4'h0, 12'h0FC, 13'd8);
        chk(r_err == 1'b1, "R8 offset below base", 32'(r_err), 1);
        run(1'b1, 16'h0030, 4'h0, 12'hFF8, 13'd9);
        chk(r_err == 1'b1, "R8 exceeds space", 32'(r_err), 1);
        run(1'b1, 16'h0030, 4'h0, 12'h200, 13'd7);
        chk(r_err == 1'b1, "R8 size too small", 32'(r_err), 1);
        run(1'b1, 16'h0030, 4'h0, 12'h202, 13'd8);
        chk(r_err == 1'b1, "R8 misaligned offset", 32'(r_err), 1);
        chk(wr_count == w0, "R8 no writes", wr_count, w0);
        run(1'b1, 16'h0030, 4'h3, 12'hFF8, 13'd8);
        chk(!r_err && r_prev == 12'h100, "R8 exact fit accepted", {r_err, r_prev}, 13'h100);
        chk(ram[10'h3FE] == mk(12'h0, 4'h3, 16'h0030), "R7 new header", ram[10'h3FE], mk(12'h0, 4'h3, 16'h0030));
        chk(ram[10'h040] == mk(12'hFF8, 4'h0, 16'h0001), "R7 tail patched", ram[10'h040], mk(12'hFF8, 4'h0, 16'h0001));

        // R10 start while busy ignored, results held
        w0 = wr_count;
        @(negedge clk);
        cmd_i = 1'b0; id_i = 16'hFFFF; start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        @(negedge clk);
        cmd_i = 1'b1; id_i = 16'h0044; off_i = 12'h100; size_i = 13'd8; start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (!done_o) @(negedge clk);
        chk(!err_o && found_off_o == 0 && prev_off_o == 12'hFF8, "R10 busy start ignored",
            {err_o, found_off_o, prev_off_o}, {1'b0, 12'h0, 12'hFF8});
        repeat (6) @(negedge clk);
        chk(!busy_o && prev_off_o == 12'hFF8, "R10 results held", prev_off_o, 12'hFF8);
        chk(wr_count == w0, "R10 no write from ignored start", wr_count, w0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule